// File: doc/BRIEF.md
# Polled Console Register Window

This peripheral sits on a simple synchronous processor bus and exposes one receive channel and one transmit channel as four 32-bit registers in a reserved window at the top of the address space. The window starts at 0xFFFF0000 and holds no ordinary memory. Software finds out whether a channel is ready by polling bit 0 of that channel's status word, masked with 0x1. It then loads the received byte or stores a byte to send.

A ready flag is always seen from the processor's side: 1 means "you may read now" (receive) or "you may write now" (transmit). The device side sets the flag. A receive flag is set when a byte arrives. A transmit flag is set when the previous byte has been handed off. The processor's access to the matching data word clears the flag as a side effect.

The receive port is a valid strobe with no back-pressure. A byte offered while the receive flag is already 1 replaces the held byte. The transmit port is valid/ready. The block holds `tx_valid` high and `tx_data` steady until the sink raises `tx_ready`. A transfer happens on any clock edge where both are high.

Top module: `console_mmio`

Register map, as offsets from 0xFFFF0000:
- 0x0: receive status. Bit 0 is the receive flag.
- 0x4: received byte.
- 0x8: transmit status. Bit 0 is the transmit flag.
- 0xC: byte to send.

## Requirements
- R1: After reset the receive flag is 0, the transmit flag is 1, `tx_valid` is 0 and `bus_rdata` is 0.
- R2: A load from offset 0x0 returns the receive flag in bit 0. A load from offset 0x8 returns the transmit flag in bit 0. Bits 31 to 1 of both status words read 0. Load data appears on `bus_rdata` in the cycle after the `bus_rd` edge and holds until the next load.
- R3: When `rx_valid` is high, the block captures `rx_data` and sets the receive flag. A load from offset 0x4 returns that byte zero-extended to 32 bits and clears the receive flag.
- R4: A byte that arrives while the receive flag is 1 replaces the held byte, and the flag stays 1.
- R5: If a byte arrives in the same cycle as a load from offset 0x4, the load returns the previously held byte. The flag stays 1 and the new byte is held for the next load.
- R6: A store to offset 0xC while the transmit flag is 1 raises `tx_valid` in the next cycle with `tx_data` equal to bits 7 to 0 of the store data. The same store clears the transmit flag.
- R7: `tx_valid` and `tx_data` hold while `tx_ready` is 0. A cycle with both `tx_valid` and `tx_ready` high drops `tx_valid` and sets the transmit flag.
- R8: A store to offset 0xC while the transmit flag is 0 is ignored, and the pending byte is unchanged.
- R9: Stores to offsets 0x0 and 0x8 change nothing.
- R10: Loads from unmapped offsets inside the window, and from any address outside it, return 0 and clear no flag. Stores to such addresses send nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, registered |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to send is valid |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Sink takes the byte |

## Verification
Two receive events can fall on the same edge: a new byte arriving, and the processor's load that clears the flag. The bench provokes this by raising `rx_valid` in the same cycle as a load of offset 0x4. It then checks three things:
- the load returned the old byte;
- a status load shows the flag still set;
- a second data load returns the new byte.

On the transmit side, a store can land while an earlier byte is still waiting for `tx_ready`. The bench judges that case by seeing `tx_data` unchanged.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;
  localparam int unsigned OFS_RX_STAT = 0;
  localparam int unsigned OFS_RX_BYTE = 4;
  localparam int unsigned OFS_TX_STAT = 8;
  localparam int unsigned OFS_TX_BYTE = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_BYTE,
    SEL_TX_STAT,
    SEL_TX_BYTE
  } reg_sel_e;
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000,
  parameter int unsigned WIN_BITS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

  logic             in_win;
  logic [WIN_BITS-1:0] ofs;

  assign in_win = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  assign ofs    = addr[WIN_BITS-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      case (ofs)
        WIN_BITS'(OFS_RX_STAT): sel = SEL_RX_STAT;
        WIN_BITS'(OFS_RX_BYTE): sel = SEL_RX_BYTE;
        WIN_BITS'(OFS_TX_STAT): sel = SEL_TX_STAT;
        WIN_BITS'(OFS_TX_BYTE): sel = SEL_TX_BYTE;
        default:                sel = SEL_NONE;
      endcase
    end
  end

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = BASE[TAG_W-1:0];
endmodule

// File: rtl/console_rx.sv
module console_rx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              take,
  output logic              flag,
  output logic [BYTE_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      held <= '0;
    end else if (in_valid) begin
      flag <= 1'b1;
      held <= in_byte;
    end else if (take) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/console_tx.sv
module console_tx #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              put,
  input  logic [BYTE_W-1:0] put_byte,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              flag
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      out_byte <= '0;
    end else if (pend) begin
      if (out_ready) pend <= 1'b0;
    end else if (put) begin
      pend     <= 1'b1;
      out_byte <= put_byte;
    end
  end

  assign out_valid = pend;
  assign flag      = ~pend;
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_mmio_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000,
  parameter int unsigned WIN_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  reg_sel_e          sel;
  logic              rx_flag;
  logic [BYTE_W-1:0] rx_held;
  logic              tx_flag;
  logic [DATA_W-1:0] rd_mux;

  console_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .WIN_BITS(WIN_BITS)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  console_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_valid), .in_byte(rx_data),
    .take(bus_rd && sel == SEL_RX_BYTE),
    .flag(rx_flag), .held(rx_held)
  );

  console_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .put(bus_wr && sel == SEL_TX_BYTE),
    .put_byte(bus_wdata[BYTE_W-1:0]),
    .out_ready(tx_ready), .out_valid(tx_valid),
    .out_byte(tx_data), .flag(tx_flag)
  );

  always_comb begin
    case (sel)
      SEL_RX_STAT: rd_mux = {{(DATA_W-1){1'b0}}, rx_flag};
      SEL_RX_BYTE: rd_mux = {{PAD_W{1'b0}}, rx_held};
      SEL_TX_STAT: rd_mux = {{(DATA_W-1){1'b0}}, tx_flag};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/console_mmio_chk.sv
module console_mmio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        rx_valid,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_ready,
  input logic        rx_flag
);
  logic a_rxs, a_rxb, a_txs, a_txb, a_map;
  assign a_rxs = bus_addr == 32'hFFFF_0000;
  assign a_rxb = bus_addr == 32'hFFFF_0004;
  assign a_txs = bus_addr == 32'hFFFF_0008;
  assign a_txb = bus_addr == 32'hFFFF_000C;
  assign a_map = a_rxs | a_rxb | a_txs | a_txb;

  AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (a_rxs || a_txs) |=> bus_rdata[31:1] == 31'd0); // R2
  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_flag); // R3
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && a_rxb && !rx_valid |=> !rx_flag); // R3
  AST_TX_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && a_txb && !tx_valid |=> tx_valid && tx_data == $past(bus_wdata[7:0])); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R7
  AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !a_map |=> bus_rdata == 32'd0); // R10
  AST_UNMAPPED_NOSEND: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !(bus_wr && a_txb) |=> !tx_valid); // R10
endmodule

bind console_mmio console_mmio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .rx_flag(rx_flag)
);

// File: tb/test_console_mmio.sv
module test_console_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [31:0] RXS = 32'hFFFF_0000;
  localparam logic [31:0] RXB = 32'hFFFF_0004;
  localparam logic [31:0] TXS = 32'hFFFF_0008;
  localparam logic [31:0] TXB = 32'hFFFF_000C;

  always #10 clk = ~clk;

  console_mmio i_console_mmio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    rd(RXS, d); check("R1 rx flag", d, 32'd0);
    rd(TXS, d); check("R1 tx flag", d, 32'd1);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    push(8'hA5);
    rd(RXS, d); check("R2 rx status", d, 32'd1);
    rd(RXB, d); check("R3 rx byte", d, 32'h0000_00A5);
    rd(RXS, d); check("R3 rx cleared", d, 32'd0);
    @(negedge clk);
    check("R2 rdata holds", bus_rdata, 32'd0);
  endtask

  task automatic t_rx_overwrite;
    logic [31:0] d;
    push(8'h11);
    push(8'hF0);
    rd(RXS, d); check("R4 flag stays", d, 32'd1);
    rd(RXB, d); check("R4 newest byte", d, 32'h0000_00F0);
  endtask

  task automatic t_rx_collide;
    logic [31:0] d;
    push(8'h3C);
    @(negedge clk);
    bus_addr = RXB; bus_rd = 1'b1; rx_data = 8'hC3; rx_valid = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_valid = 1'b0;
    check("R5 old byte", bus_rdata, 32'h0000_003C);
    rd(RXS, d); check("R5 flag kept", d, 32'd1);
    rd(RXB, d); check("R5 new byte", d, 32'h0000_00C3);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    wr(TXB, 32'hDEAD_BE5A);
    check("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
    check("R6 tx_data", {24'd0, tx_data}, 32'h5A);
    rd(TXS, d); check("R6 flag cleared", d, 32'd0);
    wr(TXB, 32'h0000_0077);
    check("R8 busy store dropped", {24'd0, tx_data}, 32'h5A);
    repeat (3) @(negedge clk);
    check("R7 hold valid", {31'd0, tx_valid}, 32'd1);
    check("R7 hold data", {24'd0, tx_data}, 32'h5A);
    tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R7 valid dropped", {31'd0, tx_valid}, 32'd0);
    rd(TXS, d); check("R7 flag set", d, 32'd1);
  endtask

  task automatic t_ctrl_writes;
    logic [31:0] d;
    wr(RXS, 32'hFFFF_FFFF);
    wr(TXS, 32'h0000_0000);
    rd(RXS, d); check("R9 rx status", d, 32'd0);
    rd(TXS, d); check("R9 tx status", d, 32'd1);
    check("R9 no send", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    push(8'h42);
    rd(32'hFFFF_0010, d); check("R10 window hole", d, 32'd0);
    rd(32'hFFFF_0002, d); check("R10 unaligned", d, 32'd0);
    rd(32'h0000_0004, d); check("R10 outside", d, 32'd0);
    wr(32'h0000_000C, 32'h99);
    wr(32'hFFFF_001C, 32'h99);
    check("R10 no send", {31'd0, tx_valid}, 32'd0);
    rd(RXS, d); check("R10 rx flag kept", d, 32'd1);
    rd(RXB, d); check("R10 byte kept", d, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_basic();
    t_rx_overwrite();
    t_rx_collide();
    t_tx();
    t_ctrl_writes();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule